// File: doc/BRIEF.md
# Event Ring Record Writer

This block takes fault or status records from an upstream producer one at a time and appends each to a circular buffer in system memory. The ring holds a power-of-two number of fixed-size entries. Software owns the consumer pointer and the block owns the producer pointer. Both pointers carry one extra wrap bit above the slot index, so an empty ring and a full ring can be told apart without wasting a slot.

For each accepted record the block first checks two things. If the ring is switched off, or if it has no free slot, the record is thrown away and no memory traffic is issued. Otherwise the block issues a single write request to the slot the producer pointer names and waits for the memory response. The producer pointer moves forward only when the response reports success. A one-cycle interrupt pulse then tells software that a ring which was empty now holds data. Records dropped because the ring was full are tallied in a saturating counter.

Top module: `evq_record_writer`

## Requirements
- R1: After reset the producer pointer is 0, the drop counter is 0, no memory request or interrupt is active, and `evt_ready` is 1.
- R2: A record accepted while `ring_on` is 0 is discarded: no memory request is issued, and neither the producer pointer nor the drop counter changes.
- R3: A record accepted while the ring is full is discarded without a memory request, and the drop counter increases by one. Full means the index bits are equal and the wrap bits (bit IDX_W) differ. The counter saturates at its all-ones value.
- R4: For a record that is kept, `mem_req` is high for exactly one cycle, in the cycle after acceptance. The address is `ring_base + index * (REC_W/8)`, where index is the low IDX_W bits of the producer pointer. The write data is the accepted record.
- R5: A response with `mem_rsp_err` = 0 advances the producer pointer by one. When the index passes the last slot it returns to 0 and the wrap bit toggles.
- R6: A response with `mem_rsp_err` = 1 leaves the producer pointer unchanged and raises no interrupt.
- R7: `evq_irq` is a single-cycle pulse in the cycle after a successful response. It fires only if the ring was empty (producer pointer equal to consumer pointer, including the wrap bit) when the record was accepted.
- R8: `evt_ready` is 0 from the cycle after a kept record is accepted until the cycle after its response, so at most one write is outstanding.
- R9: Both kinds of discard complete in the acceptance cycle, and `evt_ready` stays 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_on | input | 1 | Ring enable; 0 makes every record be discarded |
| ring_base | input | ADDR_W | Byte address of slot 0 |
| cons_ptr | input | IDX_W+1 | Consumer pointer: wrap bit on top of the slot index |
| evt_valid | input | 1 | Record offered |
| evt_ready | output | 1 | Block can take a record |
| evt_data | input | REC_W | Record contents |
| mem_req | output | 1 | One-cycle write request |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | REC_W | Write data |
| mem_rsp_valid | input | 1 | Write response present |
| mem_rsp_err | input | 1 | Response reports a failed write |
| prod_ptr | output | IDX_W+1 | Producer pointer: wrap bit on top of the slot index |
| evq_irq | output | 1 | Pulse: an empty ring received a record |
| drop_cnt | output | CNT_W | Saturating count of records dropped because the ring was full |

## Verification
The main write path is exercised against four ring states:
- **Empty ring:** tells apart whether the interrupt fires.
- **Partly filled ring:** checks that the interrupt stays quiet.
- **Ring drained back to empty:** checks that emptiness compares the full pointer, not an old index.
- **Fill across the last slot:** shows the address wrapping to the base and the wrap bit toggling.

A failed response on an empty ring separates the success-only pointer advance and interrupt from a design that acts on any response. Disabled and full discards are sent back to back; this separates the two discard causes by whether the drop counter moves, and shows that neither one stalls the handshake. A long run of full discards pushes the counter into saturation.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } evq_state_e;
endpackage

// File: rtl/evq_rst_sync.sv
module evq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/evq_ptr_math.sv
module evq_ptr_math #(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W:0] prod,
  input  logic [IDX_W:0] cons,
  output logic           ring_empty,
  output logic           ring_full,
  output logic [IDX_W:0] prod_next
);
  logic same_idx;
  logic same_wrap;

  always_comb begin
    same_idx   = (prod[IDX_W-1:0] == cons[IDX_W-1:0]);
    same_wrap  = (prod[IDX_W] == cons[IDX_W]);
    ring_empty = same_idx && same_wrap;
    ring_full  = same_idx && !same_wrap;
    prod_next  = prod + {{IDX_W{1'b0}}, 1'b1};
  end
endmodule

// File: rtl/evq_drop_counter.sv
module evq_drop_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = bump && (count != CNT_MAX);
    count_d  = count + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end

  a_r3_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> (count == $past(count) + 1'b1) && $past(bump));
  a_r3_drop_sat: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == CNT_MAX) |-> (count == CNT_MAX));
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_valid,
  input  logic ring_on,
  input  logic ring_empty,
  input  logic ring_full,
  input  logic rsp_valid,
  input  logic rsp_err,
  output logic evt_ready,
  output logic capture,
  output logic issue,
  output logic advance,
  output logic drop_full,
  output logic irq
);
  evq_state_e state_q, state_d;
  logic       was_empty_q;
  logic       irq_d;
  logic       accept;

  always_comb begin
    evt_ready = (state_q == ST_IDLE);
    accept    = evt_valid && evt_ready;
    capture   = accept && ring_on && !ring_full;
    drop_full = accept && ring_on && ring_full;
    issue     = (state_q == ST_ISSUE);
    advance   = (state_q == ST_WAIT) && rsp_valid && !rsp_err;
    irq_d     = advance && was_empty_q;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE:  if (capture)   state_d = ST_ISSUE;
      ST_ISSUE:                state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      was_empty_q <= 1'b0;
      irq         <= 1'b0;
    end else begin
      state_q <= state_d;
      irq     <= irq_d;
      if (capture) was_empty_q <= ring_empty;
    end
  end

  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);
  a_r4_req_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> issue);
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !evt_ready);
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r6_no_irq_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |=> !irq);
  a_r9_discard_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !capture) |=> evt_ready);
endmodule

// File: rtl/evq_record_writer.sv
module evq_record_writer #(
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 32,
  parameter int REC_W  = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_on,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [IDX_W:0]    cons_ptr,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [REC_W-1:0]  evt_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REC_W-1:0]  mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  output logic [IDX_W:0]    prod_ptr,
  output logic              evq_irq,
  output logic [CNT_W-1:0]  drop_cnt
);
  localparam int ENT_BYTES = REC_W / 8;
  localparam int ENT_SH    = $clog2(ENT_BYTES);

  logic              rst_sync_n;
  logic              ring_empty, ring_full;
  logic [IDX_W:0]    prod_next;
  logic              capture, advance, drop_full;
  logic [ADDR_W-1:0] slot_addr;

  evq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  evq_ptr_math #(.IDX_W(IDX_W)) u_ptr (
    .prod(prod_ptr), .cons(cons_ptr),
    .ring_empty(ring_empty), .ring_full(ring_full), .prod_next(prod_next)
  );

  evq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .evt_valid(evt_valid), .ring_on(ring_on),
    .ring_empty(ring_empty), .ring_full(ring_full),
    .rsp_valid(mem_rsp_valid), .rsp_err(mem_rsp_err),
    .evt_ready(evt_ready), .capture(capture), .issue(mem_req),
    .advance(advance), .drop_full(drop_full), .irq(evq_irq)
  );

  evq_drop_counter #(.CNT_W(CNT_W)) u_drop (
    .clk(clk), .rst_n(rst_sync_n), .bump(drop_full), .count(drop_cnt)
  );

  always_comb begin
    slot_addr = ring_base + (ADDR_W'(prod_ptr[IDX_W-1:0]) << ENT_SH);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prod_ptr  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      if (advance) prod_ptr <= prod_next;
      if (capture) begin
        mem_addr  <= slot_addr;
        mem_wdata <= evt_data;
      end
    end
  end

  a_r5_prod_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(prod_ptr) |-> (prod_ptr == $past(prod_ptr) + 1'b1));
  a_r5_prod_only_on_ok: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(prod_ptr) |-> $past(mem_rsp_valid && !mem_rsp_err));
  a_r2_off_no_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_valid && evt_ready && !ring_on) |=> !mem_req);
  a_r3_full_no_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_valid && evt_ready && ring_full) |=> !mem_req);
endmodule

// File: tb/sim_evq_record_writer.sv
module sim_evq_record_writer;
  localparam int IDX_W = 3, ADDR_W = 32, REC_W = 64, CNT_W = 8;
  localparam int SLOTS = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n;
  logic ring_on;
  logic [ADDR_W-1:0] ring_base;
  logic [IDX_W:0] cons_ptr;
  logic evt_valid;
  logic evt_ready;
  logic [REC_W-1:0] evt_data;
  logic mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic [REC_W-1:0] mem_wdata;
  logic mem_rsp_valid, mem_rsp_err;
  logic [IDX_W:0] prod_ptr;
  logic evq_irq;
  logic [CNT_W-1:0] drop_cnt;

  int checks = 0;
  int errors = 0;
  logic [IDX_W:0] m_prod = '0;
  int m_drop = 0;

  always #2 clk = ~clk;

  evq_record_writer #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .REC_W(REC_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ring_on(ring_on), .ring_base(ring_base),
    .cons_ptr(cons_ptr), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_data(evt_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .prod_ptr(prod_ptr), .evq_irq(evq_irq),
    .drop_cnt(drop_cnt)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Kept record: request, response after a gap, then pointer and irq checks.
  task automatic write_rec(input logic [REC_W-1:0] d, input logic err);
    logic was_empty;
    was_empty = (m_prod == cons_ptr);
    @(negedge clk);
    evt_valid = 1'b1; evt_data = d;
    @(negedge clk);
    evt_valid = 1'b0;
    check("R4 req", {63'd0, mem_req}, 64'd1);
    check("R4 addr", {32'd0, mem_addr}, {32'd0, ring_base + 32'(m_prod[IDX_W-1:0]) * (REC_W/8)});
    check("R4 data", mem_wdata, d);
    check("R8 busy", {63'd0, evt_ready}, 64'd0);
    @(negedge clk);
    check("R4 single req", {63'd0, mem_req}, 64'd0);
    check("R8 still busy", {63'd0, evt_ready}, 64'd0);
    mem_rsp_valid = 1'b1; mem_rsp_err = err;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    if (!err) m_prod = m_prod + 1'b1;
    check(err ? "R6 prod held" : "R5 prod step", {60'd0, prod_ptr}, {60'd0, m_prod});
    check("R7 irq", {63'd0, evq_irq}, {63'd0, was_empty && !err});
    check("R8 ready again", {63'd0, evt_ready}, 64'd1);
    @(negedge clk);
    check("R7 irq pulse ends", {63'd0, evq_irq}, 64'd0);
  endtask

  // Discarded record: no request, handshake free next cycle.
  task automatic discard_rec(input string req, input logic counted);
    @(negedge clk);
    evt_valid = 1'b1; evt_data = 64'hDEAD;
    @(negedge clk);
    evt_valid = 1'b0;
    if (counted && m_drop < 255) m_drop++;
    check({req, " no req"}, {63'd0, mem_req}, 64'd0);
    check("R9 ready", {63'd0, evt_ready}, 64'd1);
    check({req, " drop cnt"}, {56'd0, drop_cnt}, 64'(m_drop));
    check({req, " prod"}, {60'd0, prod_ptr}, {60'd0, m_prod});
  endtask

  task automatic t_reset;
    check("R1 prod", {60'd0, prod_ptr}, 64'd0);
    check("R1 drop", {56'd0, drop_cnt}, 64'd0);
    check("R1 req", {63'd0, mem_req}, 64'd0);
    check("R1 irq", {63'd0, evq_irq}, 64'd0);
    check("R1 ready", {63'd0, evt_ready}, 64'd1);
  endtask

  task automatic t_disabled;
    ring_on = 1'b0;
    discard_rec("R2", 1'b0);
    discard_rec("R2", 1'b0);
    ring_on = 1'b1;
  endtask

  task automatic t_basic;
    write_rec(64'h1111_2222_3333_4444, 1'b0);   // empty -> irq (R7)
    write_rec(64'h5555_6666_7777_8888, 1'b0);   // not empty -> no irq
  endtask

  task automatic t_error;
    cons_ptr = m_prod;                           // ring empty
    write_rec(64'hBAD0_BAD0_BAD0_BAD0, 1'b1);   // R6: no advance, no irq
  endtask

  task automatic t_fill_wrap;
    for (int i = 0; i < SLOTS; i++) write_rec(64'(i) + 64'hA000, 1'b0);
    check("R3 full prod", {60'd0, prod_ptr}, {60'd0, cons_ptr ^ 4'b1000});
    discard_rec("R3", 1'b1);
    ring_on = 1'b0;
    discard_rec("R2 while full", 1'b0);
    ring_on = 1'b1;
    cons_ptr = cons_ptr + 1'b1;
    write_rec(64'hC0DE, 1'b0);
    check("R5 wrap bit", {63'd0, prod_ptr[IDX_W]}, 64'd1);
  endtask

  task automatic t_drain;
    cons_ptr = m_prod;
    write_rec(64'hF00D, 1'b0);                   // R7 irq after drain
  endtask

  task automatic t_saturate;
    cons_ptr = m_prod ^ 4'b1000;                 // full
    for (int i = 0; i < 260; i++) discard_rec("R3 sat", 1'b1);
    check("R3 saturated", {56'd0, drop_cnt}, 64'd255);
  endtask

  initial begin
    rst_n = 1'b0; ring_on = 1'b1; ring_base = 32'h0000_1000; cons_ptr = '0;
    evt_valid = 1'b0; evt_data = '0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_disabled;
    t_basic;
    t_error;
    t_fill_wrap;
    t_drain;
    t_saturate;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule